// File: doc/BRIEF.md
# Wake-capable interrupt routing controller

The controller sits in an always-on power-down domain. It watches a set of external wake pins and turns qualifying pin activity into latched status bits. Each pin has its own detection mode: active low level, active high level, falling edge, rising edge, either edge, or off. Software reads the status word and clears bits by writing ones. It also decides which status bits may raise the shared wake interrupt.

A single route register steers every source to two kinds of destination. Each wake pin and each peripheral event line (real-time clock, infrared, watchdog) has its own external-interrupt enable and its own system-wakeup enable. The per-pin interrupt outputs and the peripheral interrupt outputs follow the external enables. The single system wakeup output is the OR of all sources whose wakeup enable is set. Access is through a plain 32-bit register port with separate read and write strobes. Reads are combinational.

Top module: `wake_route_ctrl`

## Requirements
- R1: After reset the status, enable, clear, route and auxiliary registers read 0. Every pin's mode field (config bits [3:1]) reads 4, which means off.
- R2: The level modes are mode 0, active low, and mode 1, active high. While the pin holds the active level, status bit n is set again on every cycle.
- R3: The edge modes are mode 2, falling, mode 3, rising, and mode 6, either edge. Each qualifying transition of the synchronized pin sets status bit n once. A pin held steady does not set it again after a clear.
- R4: Writing 1 to bit n at offset 0x318 clears status bit n unless a detection lands in the same cycle, in which case the detection wins. A level-mode bit stays set after a clear while the pin is still active.
- R5: wake_irq_o is high exactly when the status (0x310) AND enable (0x314) over the implemented pins is non-zero.
- R6: pin_irq_o[n] equals status bit n gated by route bit 8+n.
- R7: perip_irq_o[k] equals peripheral line k gated by route bit k, with k = 0 RTC, 1 IR, 2 watchdog.
- R8: sys_wake_o is the OR of status bit n gated by route bit 24+n and peripheral line k gated by route bit 16+k.
- R9: Pin n's config register sits at 0x330+8n. Bit 0 reads the pin value after a two-flop synchronizer, and bits [4:1] read back as written. Status follows a pin change on the third rising clock edge.
- R10: While config bit 4 of pin n is 1, no mode sets status bit n.
- R11: Modes 4, 5 and 7 never set status. Writes to unmapped offsets and to the status register have no effect. Reads of unmapped offsets return 0, and rdata_o is 0 when rd_en_i is low.
- R12: The enable (0x314, bits [3:0]), route (0x31C) and auxiliary (0x334+8n, 32 bits) registers read back what was written. Only the implemented route bits are kept: 0-2, 8-11, 16-18 and 24-27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| wake_pin_i | input | 4 | Asynchronous wake pins |
| perip_evt_i | input | 3 | Peripheral event lines (RTC, IR, watchdog) |
| wake_irq_o | output | 1 | Shared wake interrupt |
| pin_irq_o | output | 4 | Routed per-pin interrupts |
| perip_irq_o | output | 3 | Routed peripheral interrupts |
| sys_wake_o | output | 1 | System wakeup request |

## Verification
The hardest case to reach is a detection and a clear landing on the same status bit in the same cycle, together with the cases around it: a clear issued while a level pin is still active, and an edge arriving while its pin is held in reset through config bit 4. Directed sequences place pin changes a known number of edges before the clear or config write. A long random phase then flips pins sparsely while writing random mode values, including the unused codes 5 and 7, reset bits and clear masks. Every output and the read port are compared each cycle against a bench model of the registers.

// File: rtl/wake_route_pkg.sv
package wake_route_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    MODE_LVL_LO = 3'd0,
    MODE_LVL_HI = 3'd1,
    MODE_FALL   = 3'd2,
    MODE_RISE   = 3'd3,
    MODE_OFF    = 3'd4,
    MODE_ANY    = 3'd6
  } mode_e;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h310;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h314;
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = 12'h318;
  localparam logic [ADDR_W-1:0] OFF_ROUTE  = 12'h31C;
  localparam logic [ADDR_W-1:0] OFF_CFG0   = 12'h330;

  localparam int ROUTE_PIN_EXT  = 8;
  localparam int ROUTE_PER_WAKE = 16;
  localparam int ROUTE_PIN_WAKE = 24;

  function automatic logic [ADDR_W-1:0] cfg_addr(input int n, input bit aux);
    return OFF_CFG0 + ADDR_W'(8 * n) + (aux ? ADDR_W'(4) : ADDR_W'(0));
  endfunction
endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= pin_i;
      stg2_q <= stg1_q;
    end
  end

  assign pin_o = stg2_q;
endmodule

// File: rtl/wake_pin_detect.sv
module wake_pin_detect
  import wake_route_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic [2:0] mode_i,
  input  logic       hold_i,
  output logic       hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= smp_i;
  end

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    hit_o = 1'b0;
    if (!hold_i) begin
      case (mode_i)
        MODE_LVL_LO: hit_o = ~smp_i;
        MODE_LVL_HI: hit_o = smp_i;
        MODE_FALL:   hit_o = fall;
        MODE_RISE:   hit_o = rise;
        MODE_ANY:    hit_o = rise | fall;
        default:     hit_o = 1'b0;
      endcase
    end
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RISE && hit_o) |=> (!hit_o || mode_i != MODE_RISE)); // R3
endmodule

// File: rtl/wake_route_ctrl.sv
module wake_route_ctrl
  import wake_route_pkg::*;
#(
  parameter int NUM_WAKE  = 4,
  parameter int NUM_PERIP = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_WAKE-1:0]  wake_pin_i,
  input  logic [NUM_PERIP-1:0] perip_evt_i,
  output logic                 wake_irq_o,
  output logic [NUM_WAKE-1:0]  pin_irq_o,
  output logic [NUM_PERIP-1:0] perip_irq_o,
  output logic                 sys_wake_o
);
  localparam logic [31:0] PIN_ONES = (32'd1 << NUM_WAKE) - 32'd1;
  localparam logic [31:0] PER_ONES = (32'd1 << NUM_PERIP) - 32'd1;
  localparam logic [31:0] ROUTE_MASK = PER_ONES | (PIN_ONES << ROUTE_PIN_EXT)
                                     | (PER_ONES << ROUTE_PER_WAKE)
                                     | (PIN_ONES << ROUTE_PIN_WAKE);

  logic [NUM_WAKE-1:0] sync_pin, hit, status_q, enable_q, hold_q, clr_mask;
  logic [2:0]          mode_q [NUM_WAKE];
  logic [31:0]         aux_q  [NUM_WAKE];
  logic [31:0]         route_q;
  logic                wr_status, wr_enable, wr_clear, wr_route;
  logic [NUM_WAKE-1:0] wr_cfg, wr_aux;

  wake_pin_sync #(.W(NUM_WAKE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (wake_pin_i),
    .pin_o (sync_pin)
  );

  assign wr_status = wr_en_i && addr_i == OFF_STATUS;
  assign wr_enable = wr_en_i && addr_i == OFF_ENABLE;
  assign wr_clear  = wr_en_i && addr_i == OFF_CLEAR;
  assign wr_route  = wr_en_i && addr_i == OFF_ROUTE;
  assign clr_mask  = wr_clear ? wdata_i[NUM_WAKE-1:0] : '0;

  for (genvar n = 0; n < NUM_WAKE; n++) begin : g_pin
    assign wr_cfg[n] = wr_en_i && addr_i == cfg_addr(n, 1'b0);
    assign wr_aux[n] = wr_en_i && addr_i == cfg_addr(n, 1'b1);

    wake_pin_detect u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (sync_pin[n]),
      .mode_i(mode_q[n]),
      .hold_i(hold_q[n]),
      .hit_o (hit[n])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[n] <= MODE_OFF;
        hold_q[n] <= 1'b0;
        aux_q[n]  <= '0;
      end else begin
        if (wr_cfg[n]) begin
          mode_q[n] <= wdata_i[3:1];
          hold_q[n] <= wdata_i[4];
        end
        if (wr_aux[n]) aux_q[n] <= wdata_i;
      end
    end

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_clear && wdata_i[n] && !hit[n]) |=> !status_q[n]); // R4
    AST_LEVEL_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[n] == MODE_LVL_HI && sync_pin[n] && !hold_q[n]) |=> status_q[n]); // R2
    AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_q[n] && !status_q[n]) |=> !status_q[n]); // R10
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      route_q  <= '0;
    end else begin
      // detection wins over a same-cycle clear
      status_q <= (status_q & ~clr_mask) | hit;
      if (wr_enable) enable_q <= wdata_i[NUM_WAKE-1:0];
      if (wr_route)  route_q  <= wdata_i & ROUTE_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == OFF_STATUS) rdata_o = 32'(status_q);
      if (addr_i == OFF_ENABLE) rdata_o = 32'(enable_q);
      if (addr_i == OFF_ROUTE)  rdata_o = route_q;
      for (int n = 0; n < NUM_WAKE; n++) begin
        if (addr_i == cfg_addr(n, 1'b0)) rdata_o = {27'd0, hold_q[n], mode_q[n], sync_pin[n]};
        if (addr_i == cfg_addr(n, 1'b1)) rdata_o = aux_q[n];
      end
    end
  end

  assign wake_irq_o  = |(status_q & enable_q);
  assign pin_irq_o   = status_q & route_q[ROUTE_PIN_EXT +: NUM_WAKE];
  assign perip_irq_o = perip_evt_i & route_q[0 +: NUM_PERIP];
  assign sys_wake_o  = |(status_q & route_q[ROUTE_PIN_WAKE +: NUM_WAKE])
                     | |(perip_evt_i & route_q[ROUTE_PER_WAKE +: NUM_PERIP]);

  AST_STATUS_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status && hit == '0) |=> $stable(status_q)); // R11
endmodule

// File: tb/test_wake_route_ctrl.sv
module test_wake_route_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NP = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NW-1:0] wake_pin = '0, pin_irq;
  logic [NP-1:0] perip = '0, perip_irq;
  logic wake_irq, sys_wake;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_route_ctrl i_wake_route_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wake_pin_i(wake_pin), .perip_evt_i(perip), .wake_irq_o(wake_irq),
    .pin_irq_o(pin_irq), .perip_irq_o(perip_irq), .sys_wake_o(sys_wake)
  );

  // reference model
  logic [NW-1:0] m_s1, m_s2, m_prev, m_status, m_en, m_rst, m_hit;
  logic [2:0]    m_mode [NW];
  logic [31:0]   m_aux [NW];
  logic [31:0]   m_route;
  localparam logic [31:0] RMASK = 32'h0F07_0F07;

  function automatic logic det(input logic [2:0] md, input logic s, input logic p);
    case (md)
      3'd0: return !s;
      3'd1: return s;
      3'd2: return !s && p;
      3'd3: return s && !p;
      3'd6: return s != p;
      default: return 1'b0;
    endcase
  endfunction

  always_comb
    for (int n = 0; n < NW; n++) m_hit[n] = !m_rst[n] && det(m_mode[n], m_s2[n], m_prev[n]);

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_status <= '0;
      m_en <= '0; m_rst <= '0; m_route <= '0;
      for (int n = 0; n < NW; n++) begin m_mode[n] <= 3'd4; m_aux[n] <= '0; end
    end else begin
      m_s1 <= wake_pin; m_s2 <= m_s1; m_prev <= m_s2;
      m_status <= (m_status & ~((wr_en && addr == 12'h318) ? wdata[NW-1:0] : 4'h0)) | m_hit;
      if (wr_en && addr == 12'h314) m_en <= wdata[NW-1:0];
      if (wr_en && addr == 12'h31C) m_route <= wdata & RMASK;
      for (int n = 0; n < NW; n++) begin
        if (wr_en && addr == 12'h330 + 12'(8*n)) begin
          m_mode[n] <= wdata[3:1]; m_rst[n] <= wdata[4];
        end
        if (wr_en && addr == 12'h334 + 12'(8*n)) m_aux[n] <= wdata;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic re, input logic [11:0] a);
    if (!re) return '0;
    if (a == 12'h310) return 32'(m_status);
    if (a == 12'h314) return 32'(m_en);
    if (a == 12'h31C) return m_route;
    for (int n = 0; n < NW; n++) begin
      if (a == 12'h330 + 12'(8*n)) return {27'd0, m_rst[n], m_mode[n], m_s2[n]};
      if (a == 12'h334 + 12'(8*n)) return m_aux[n];
    end
    return '0;
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    if (a == 12'h310) return "R4";
    if (a >= 12'h330 && a < 12'h350 && a[2:0] == 3'd0) return "R9";
    if (a == 12'h314 || a == 12'h31C || (a >= 12'h330 && a < 12'h350 && a[2:0] == 3'd4)) return "R12";
    return "R11";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a; #1;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic model_cmp();
    chk("R5", 32'(wake_irq), 32'(|(m_status & m_en)));
    chk("R6", 32'(pin_irq), 32'(m_status & m_route[11:8]));
    chk("R7", 32'(perip_irq), 32'(perip & m_route[2:0]));
    chk("R8", 32'(sys_wake), 32'((|(m_status & m_route[27:24])) | (|(perip & m_route[18:16]))));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);
    // R1 reset values
    rd(12'h310, 0, "R1"); rd(12'h314, 0, "R1"); rd(12'h318, 0, "R1"); rd(12'h31C, 0, "R1");
    for (int n = 0; n < NW; n++) begin
      rd(12'h330 + 12'(8*n), 32'h8, "R1");
      rd(12'h334 + 12'(8*n), 32'h0, "R1");
    end
    chk("R1", 32'({wake_irq, sys_wake, pin_irq, perip_irq}), 0);

    // R3 rising edge on pin 0, R9 readback
    wr(12'h330, 32'h6);
    wake_pin[0] = 1'b1; wait_cyc(4);
    rd(12'h310, 32'h1, "R3");
    rd(12'h330, 32'h7, "R9");
    wr(12'h318, 32'h1); wait_cyc(2);
    rd(12'h310, 32'h0, "R3");
    wake_pin[0] = 1'b0; wait_cyc(4);
    rd(12'h310, 32'h0, "R3");

    // R9 synchronizer latency: status appears on third edge
    wake_pin[0] = 1'b1; wait_cyc(2);
    rd(12'h310, 32'h0, "R9");
    wait_cyc(1);
    rd(12'h310, 32'h1, "R9");
    wr(12'h318, 32'h1);

    // R2 / R4 level high on pin 1
    wr(12'h338, 32'h2);
    wake_pin[1] = 1'b1; wait_cyc(4);
    rd(12'h310, 32'h2, "R2");
    wr(12'h318, 32'h2); wait_cyc(2);
    rd(12'h310, 32'h2, "R4");
    wake_pin[1] = 1'b0; wait_cyc(4);
    wr(12'h318, 32'h2); wait_cyc(2);
    rd(12'h310, 32'h0, "R4");

    // R2 level low on pin 3, R5 enable
    wr(12'h348, 32'h0); wait_cyc(2);
    rd(12'h310, 32'h8, "R2");
    chk("R5", 32'(wake_irq), 0);
    wr(12'h314, 32'h8);
    chk("R5", 32'(wake_irq), 1);
    wr(12'h348, 32'h8);
    wr(12'h318, 32'h8); wait_cyc(2);
    rd(12'h310, 32'h0, "R11");
    chk("R5", 32'(wake_irq), 0);
    wr(12'h314, 32'h0);

    // R10 detection reset on pin 2, then R3 either edge
    wr(12'h340, 32'h1C);
    wake_pin[2] = 1'b1; wait_cyc(4);
    wake_pin[2] = 1'b0; wait_cyc(4);
    rd(12'h310, 32'h0, "R10");
    wr(12'h340, 32'hC);
    wake_pin[2] = 1'b1; wait_cyc(4);
    rd(12'h310, 32'h4, "R3");
    wr(12'h318, 32'h4);
    wake_pin[2] = 1'b0; wait_cyc(4);
    rd(12'h310, 32'h4, "R3");
    wr(12'h318, 32'h4);

    // R11 ignored writes
    wr(12'h320, 32'hFFFF_FFFF);
    rd(12'h320, 32'h0, "R11");
    wr(12'h310, 32'hF);
    rd(12'h310, 32'h0, "R11");
    rd_en = 1'b0; addr = 12'h31C; #1;
    chk("R11", rdata, 0);

    // R7 / R8 / R6 routing
    perip = 3'b010;
    wr(12'h31C, 32'h0002_0000);
    chk("R8", 32'(sys_wake), 1);
    chk("R7", 32'(perip_irq), 0);
    wr(12'h31C, 32'h0000_0002);
    chk("R7", 32'(perip_irq), 32'h2);
    chk("R8", 32'(sys_wake), 0);
    wr(12'h31C, 32'hFFFF_FFFF);
    rd(12'h31C, RMASK, "R12");
    wr(12'h31C, 32'h0000_0100);
    wake_pin[0] = 1'b0; wait_cyc(4);
    wake_pin[0] = 1'b1; wait_cyc(4);
    chk("R6", 32'(pin_irq), 32'h1);
    chk("R8", 32'(sys_wake), 0);
    wr(12'h31C, 32'h0100_0000);
    chk("R8", 32'(sys_wake), 1);
    chk("R6", 32'(pin_irq), 0);
    wr(12'h318, 32'hF);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      model_cmp();
      wr_en = ($urandom % 100) < 15;
      rd_en = ($urandom % 100) < 85;
      case ($urandom % 12)
        0: addr = 12'h310;
        1: addr = 12'h314;
        2, 3: addr = 12'h318;
        4: addr = 12'h31C;
        5, 6, 7, 8: addr = 12'h330 + 12'(8 * ($urandom % NW));
        9: addr = 12'h334 + 12'(8 * ($urandom % NW));
        default: addr = 12'($urandom);
      endcase
      wdata = (addr >= 12'h330 && addr < 12'h350) ? ($urandom % 32) : $urandom;
      if (addr >= 12'h330 && addr < 12'h350 && addr[2] == 1'b0 && ($urandom % 4) != 0)
        wdata[4] = 1'b0;
      for (int b = 0; b < NW; b++) if (($urandom % 10) == 0) wake_pin[b] = ~wake_pin[b];
      perip = 3'($urandom);
      #1;
      chk(rd_tag(addr), rdata, exp_rd(rd_en, addr));
    end
    @(negedge clk);
    wr_en = 1'b0;
    model_cmp();

    done = 1;
    summary();
    $finish;
  end
endmodule